// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a small RISC core whose registers are organised as overlapping windows. A 5-bit architectural register number is turned into a physical storage slot using the current window pointer (CWP). Eight global registers are shared by every window. Each window has eight private locals. Its eight "out" registers are the same storage as the eight "in" registers of the next lower window, so a caller's outgoing values appear as the callee's incoming values after a save, with no data copied.

A save moves CWP down by one and a restore moves it up by one, both modulo the window count. A window invalid mask (WIM) has one bit per window. When the window a save or restore would land on is marked invalid, the block raises an overflow or underflow indication in the same cycle and leaves CWP where it is, so that trap logic outside the block can spill or fill a window. Software-visible state can be loaded directly: CWP through a load strobe and WIM through a write strobe.

Top module: `wreg_file`

## Requirements
- R1: Register numbers 0–7 address eight globals shared by all windows. A global written while one window is current reads back the same value while any other window is current.
- R2: Register number 0 always reads as zero on both read ports. A write to register number 0 has no effect.
- R3: A save (`save_i` alone) sets CWP to (CWP−1) mod NWIN. A restore (`restore_i` alone) sets CWP to (CWP+1) mod NWIN. Both wrap around, so a save from 0 gives NWIN−1 and a restore from NWIN−1 gives 0.
- R4: A WIM bit of 1 marks its window invalid. A save whose target window (CWP−1) mod NWIN is invalid drives `ovf_o` high in that same cycle and leaves CWP unchanged. The WIM bit of the current window does not block a save.
- R5: A restore whose target window (CWP+1) mod NWIN is invalid drives `unf_o` high in that same cycle and leaves CWP unchanged.
- R6: Register numbers 8–15 (outs) of window N are the same storage as register numbers 24–31 (ins) of window (N−1) mod NWIN, at the same offset within the group.
- R7: Register numbers 16–23 (locals) are private to each window. A local written in one window is not visible in another window.
- R8: Reads are combinational. A write takes effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R9: `wim_o` bits at positions NWIN and above always read as zero, and writes to them are ignored.
- R10: After reset, CWP is 0, WIM is 0, every register reads as zero, and `ovf_o` and `unf_o` are low.
- R11: When `save_i` and `restore_i` are asserted together, neither takes effect and no indication is raised. A CWP load (`cwp_wr_en`) takes priority over a save or restore in the same cycle.

Top module parameters: `XLEN` (data width, default 32) and `NWIN` (window count, a power of two from 2 to 32, default 8). Physical storage is 8 + 16·NWIN words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears registers, CWP and WIM |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| save_i | input | 1 | Save request (move to the next lower window) |
| restore_i | input | 1 | Restore request (move to the next higher window) |
| cwp_wr_en | input | 1 | Load CWP from `cwp_wr_val` |
| cwp_wr_val | input | CW = log2(NWIN) | New CWP value |
| cwp_o | output | CW = log2(NWIN) | Current window pointer |
| wim_wr_en | input | 1 | Write WIM from `wim_wr_val` |
| wim_wr_val | input | 32 | New WIM value; bits NWIN and above are dropped |
| wim_o | output | 32 | Current WIM, zero above bit NWIN−1 |
| ovf_o | output | 1 | Save blocked by an invalid target window |
| unf_o | output | 1 | Restore blocked by an invalid target window |

## Verification
The assertions assume that every input is at a known value while reset is released and that `cwp_wr_val` is always below NWIN, which holds by its width. They also assume that register accesses made in the same cycle as a save are meant to use the old window, so no assertion links the data ports to a window change in the same cycle. The stimulus changes every input only just after a rising edge and holds it until the next one. It loads CWP and WIM through their own strobes before each save or restore case, so every window transition starts from a known pointer and mask.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
   // registers per architectural group (globals, outs, locals, ins)
   localparam int unsigned GRP_SZ = 8;
   // windowed slots per window: ins then locals
   localparam int unsigned WIN_SLOTS = 2 * GRP_SZ;
   // architectural width of the invalid mask port
   localparam int unsigned MASK_W = 32;

   typedef enum logic [1:0] {
      GRP_GLOB  = 2'd0,
      GRP_OUTS  = 2'd1,
      GRP_LOCS  = 2'd2,
      GRP_INS   = 2'd3
   } grp_e;

   // Physical slot of an architectural register for a given window.
   // Layout: globals at 0..7, then per window w a block of 16 at 8+16*w
   // (ins at offsets 0..7, locals at 8..15). Outs of w alias ins of w-1.
   function automatic int unsigned slot_of(input logic [4:0] arch,
                                           input int unsigned win,
                                           input int unsigned nwin);
      int unsigned off;
      off = int'(arch[2:0]);
      case (grp_e'(arch[4:3]))
         GRP_GLOB: slot_of = off;
         GRP_OUTS: slot_of = GRP_SZ + ((win + nwin - 1) % nwin) * WIN_SLOTS + off;
         GRP_LOCS: slot_of = GRP_SZ + win * WIN_SLOTS + GRP_SZ + off;
         default:  slot_of = GRP_SZ + win * WIN_SLOTS + off;
      endcase
   endfunction
endpackage

// File: rtl/wreg_map.sv
module wreg_map
   import wreg_pkg::*;
#(
   parameter int unsigned NWIN = 8,
   parameter int unsigned CW   = 3,
   parameter int unsigned PW   = 8
) (
   input  logic [4:0]    arch_idx,
   input  logic [CW-1:0] cwp,
   output logic [PW-1:0] phys_idx
);
   always_comb begin
      phys_idx = PW'(slot_of(arch_idx, int'(cwp), NWIN));
   end
endmodule

// File: rtl/wreg_store.sv
module wreg_store #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned DEPTH = 136,
   parameter int unsigned PW    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [PW-1:0]   raddr_a,
   input  logic [PW-1:0]   raddr_b,
   output logic [XLEN-1:0] rdata_a,
   output logic [XLEN-1:0] rdata_b
);
   logic [XLEN-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/wreg_ctrl.sv
module wreg_ctrl #(
   parameter int unsigned NWIN = 8,
   parameter int unsigned CW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            save_i,
   input  logic            restore_i,
   input  logic            cwp_wr_en,
   input  logic [CW-1:0]   cwp_wr_val,
   input  logic            wim_wr_en,
   input  logic [NWIN-1:0] wim_wr_val,
   output logic [CW-1:0]   cwp_q,
   output logic [NWIN-1:0] wim_q,
   output logic            ovf,
   output logic            unf
);
   logic [CW-1:0] cwp_dn, cwp_up, cwp_d;
   logic          do_save, do_rest;

   // NWIN is a power of two, so CW-bit wrap is modulo NWIN
   assign cwp_dn  = cwp_q - 1'b1;
   assign cwp_up  = cwp_q + 1'b1;
   assign do_save = save_i & ~restore_i;
   assign do_rest = restore_i & ~save_i;
   assign ovf     = do_save & wim_q[cwp_dn];
   assign unf     = do_rest & wim_q[cwp_up];

   always_comb begin
      cwp_d = cwp_q;
      if (cwp_wr_en)              cwp_d = cwp_wr_val;
      else if (do_save && !ovf)   cwp_d = cwp_dn;
      else if (do_rest && !unf)   cwp_d = cwp_up;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q <= '0;
         wim_q <= '0;
      end else begin
         cwp_q <= cwp_d;
         if (wim_wr_en) wim_q <= wim_wr_val;
      end
   end
endmodule

// File: rtl/wreg_file.sv
module wreg_file
   import wreg_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NWIN = 8,
   localparam int unsigned CW  = $clog2(NWIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        rd_a_idx,
   output logic [XLEN-1:0]   rd_a_data,
   input  logic [4:0]        rd_b_idx,
   output logic [XLEN-1:0]   rd_b_data,
   input  logic              wr_en,
   input  logic [4:0]        wr_idx,
   input  logic [XLEN-1:0]   wr_data,
   input  logic              save_i,
   input  logic              restore_i,
   input  logic              cwp_wr_en,
   input  logic [CW-1:0]     cwp_wr_val,
   output logic [CW-1:0]     cwp_o,
   input  logic              wim_wr_en,
   input  logic [MASK_W-1:0] wim_wr_val,
   output logic [MASK_W-1:0] wim_o,
   output logic              ovf_o,
   output logic              unf_o
);
   localparam int unsigned DEPTH = GRP_SZ + WIN_SLOTS * NWIN;
   localparam int unsigned PW    = $clog2(DEPTH);
   localparam int unsigned NPORT = 3;

   // elaboration-time parameter checks
   if (NWIN < 2 || NWIN > MASK_W || (NWIN & (NWIN - 1)) != 0) begin : g_bad_nwin
      $error("wreg_file: NWIN must be a power of two in 2..32");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("wreg_file: XLEN must be positive");
   end

   logic [NWIN-1:0]   wim_q;
   logic [NPORT-1:0][4:0]    arch_all;
   logic [NPORT-1:0][PW-1:0] phys_all;
   logic              unused_wim_hi;

   assign arch_all[0] = rd_a_idx;
   assign arch_all[1] = rd_b_idx;
   assign arch_all[2] = wr_idx;

   for (genvar p = 0; p < NPORT; p++) begin : g_map
      wreg_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
         .arch_idx (arch_all[p]),
         .cwp      (cwp_o),
         .phys_idx (phys_all[p])
      );
   end

   wreg_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .save_i     (save_i),
      .restore_i  (restore_i),
      .cwp_wr_en  (cwp_wr_en),
      .cwp_wr_val (cwp_wr_val),
      .wim_wr_en  (wim_wr_en),
      .wim_wr_val (wim_wr_val[NWIN-1:0]),
      .cwp_q      (cwp_o),
      .wim_q      (wim_q),
      .ovf        (ovf_o),
      .unf        (unf_o)
   );

   // slot 0 is never written, so register 0 stays at its reset value of zero
   wreg_store #(.XLEN(XLEN), .DEPTH(DEPTH), .PW(PW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en && (wr_idx != 5'd0)),
      .waddr   (phys_all[2]),
      .wdata   (wr_data),
      .raddr_a (phys_all[0]),
      .raddr_b (phys_all[1]),
      .rdata_a (rd_a_data),
      .rdata_b (rd_b_data)
   );

   assign wim_o         = MASK_W'(wim_q);
   assign unused_wim_hi = ^wim_wr_val;
endmodule

// File: rtl/wreg_file_chk.sv
module wreg_file_chk #(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NWIN = 8,
   localparam int unsigned CW  = $clog2(NWIN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [4:0]      rd_a_idx,
   input logic [XLEN-1:0] rd_a_data,
   input logic [4:0]      rd_b_idx,
   input logic [XLEN-1:0] rd_b_data,
   input logic            save_i,
   input logic            restore_i,
   input logic            cwp_wr_en,
   input logic [CW-1:0]   cwp_wr_val,
   input logic [CW-1:0]   cwp_o,
   input logic [31:0]     wim_o,
   input logic            ovf_o,
   input logic            unf_o
);
   // R2
   zero_rd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
   // R2
   zero_rd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
   // R3
   save_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && !restore_i && !cwp_wr_en && !ovf_o) |=> (cwp_o == CW'($past(cwp_o) - 1)));
   // R3
   restore_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_i && !save_i && !cwp_wr_en && !unf_o) |=> (cwp_o == CW'($past(cwp_o) + 1)));
   // R4
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !cwp_wr_en) |=> $stable(cwp_o));
   // R4
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (save_i && !restore_i));
   // R5
   unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_o && !cwp_wr_en) |=> $stable(cwp_o));
   // R5
   unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o |-> (restore_i && !save_i));
   // R9
   wim_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wim_o >> NWIN) == 32'd0));
   // R11
   cwp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cwp_wr_en |=> (cwp_o == $past(cwp_wr_val)));
   // R11
   both_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_i && restore_i && !cwp_wr_en) |=> $stable(cwp_o));
endmodule

bind wreg_file wreg_file_chk #(.XLEN(XLEN), .NWIN(NWIN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_a_idx   (rd_a_idx),
   .rd_a_data  (rd_a_data),
   .rd_b_idx   (rd_b_idx),
   .rd_b_data  (rd_b_data),
   .save_i     (save_i),
   .restore_i  (restore_i),
   .cwp_wr_en  (cwp_wr_en),
   .cwp_wr_val (cwp_wr_val),
   .cwp_o      (cwp_o),
   .wim_o      (wim_o),
   .ovf_o      (ovf_o),
   .unf_o      (unf_o)
);

// File: tb/wreg_file_tb.sv
module wreg_file_tb;
   localparam int XLEN = 32;
   localparam int NWIN = 8;
   localparam int CW   = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [4:0]      rd_a_idx, rd_b_idx, wr_idx;
   logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data;
   logic            wr_en, save_i, restore_i, cwp_wr_en, wim_wr_en;
   logic [CW-1:0]   cwp_wr_val, cwp_o;
   logic [31:0]     wim_wr_val, wim_o;
   logic            ovf_o, unf_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;   // 125 MHz

   wreg_file #(.XLEN(XLEN), .NWIN(NWIN)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .save_i(save_i), .restore_i(restore_i),
      .cwp_wr_en(cwp_wr_en), .cwp_wr_val(cwp_wr_val), .cwp_o(cwp_o),
      .wim_wr_en(wim_wr_en), .wim_wr_val(wim_wr_val), .wim_o(wim_o),
      .ovf_o(ovf_o), .unf_o(unf_o)
   );

   // fields: op[17:16] (1 save, 2 restore, 3 both), wim[15:8], start cwp[7:5],
   //         expected cwp[4:2], expected ovf[1], expected unf[0]
   localparam int NVEC = 9;
   localparam logic [17:0] VECS [NVEC] = '{
      {2'd1, 8'h00, 3'd0, 3'd7, 1'b0, 1'b0},   // R3 save wraps 0 -> 7
      {2'd2, 8'h00, 3'd7, 3'd0, 1'b0, 1'b0},   // R3 restore wraps 7 -> 0
      {2'd1, 8'h00, 3'd3, 3'd2, 1'b0, 1'b0},   // R3 save
      {2'd2, 8'h00, 3'd3, 3'd4, 1'b0, 1'b0},   // R3 restore
      {2'd1, 8'h04, 3'd3, 3'd3, 1'b1, 1'b0},   // R4 overflow
      {2'd2, 8'h10, 3'd3, 3'd3, 1'b0, 1'b1},   // R5 underflow
      {2'd1, 8'h80, 3'd0, 3'd0, 1'b1, 1'b0},   // R4 overflow at wrap
      {2'd3, 8'h00, 3'd5, 3'd5, 1'b0, 1'b0},   // R11 both together
      {2'd1, 8'h20, 3'd5, 3'd4, 1'b0, 1'b0}    // R4 own bit does not block
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_cwp(input logic [CW-1:0] v);
      cwp_wr_en = 1'b1; cwp_wr_val = v;
      step();
      cwp_wr_en = 1'b0;
   endtask

   task automatic set_wim(input logic [31:0] v);
      wim_wr_en = 1'b1; wim_wr_val = v;
      step();
      wim_wr_en = 1'b0;
   endtask

   task automatic wr(input logic [4:0] idx, input logic [31:0] d);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd_a(input logic [4:0] idx);
      rd_a_idx = idx;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; wr_data = '0; wr_en = 1'b0;
      save_i = 1'b0; restore_i = 1'b0; cwp_wr_en = 1'b0; cwp_wr_val = '0;
      wim_wr_en = 1'b0; wim_wr_val = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R10 reset state
      chk("R10 cwp", 32'(cwp_o), 32'd0);
      chk("R10 wim", wim_o, 32'd0);
      chk("R10 flags", {30'd0, ovf_o, unf_o}, 32'd0);
      rd_a(5'd5);
      chk("R10 global", rd_a_data, 32'd0);
      rd_a(5'd20);
      chk("R10 local", rd_a_data, 32'd0);

      // table of window moves (R3 R4 R5 R11)
      for (int i = 0; i < NVEC; i++) begin
         logic [17:0] v;
         v = VECS[i];
         set_wim({24'd0, v[15:8]});
         set_cwp(v[7:5]);
         save_i = v[16]; restore_i = v[17];
         #1;
         chk($sformatf("R4 ovf vec %0d", i), {31'd0, ovf_o}, {31'd0, v[1]});
         chk($sformatf("R5 unf vec %0d", i), {31'd0, unf_o}, {31'd0, v[0]});
         step();
         save_i = 1'b0; restore_i = 1'b0;
         chk($sformatf("R3 cwp vec %0d", i), 32'(cwp_o), 32'(v[4:2]));
      end
      set_wim(32'd0);

      // R2 register 0
      wr(5'd0, 32'hDEAD_BEEF);
      rd_a(5'd0);
      chk("R2 r0 port a", rd_a_data, 32'd0);
      rd_b_idx = 5'd0; #1;
      chk("R2 r0 port b", rd_b_data, 32'd0);

      // R1 globals shared
      set_cwp(3'd0);
      wr(5'd3, 32'h1111_2222);
      set_cwp(3'd5);
      rd_a(5'd3);
      chk("R1 global across windows", rd_a_data, 32'h1111_2222);

      // R6 outs alias next-lower ins
      set_cwp(3'd3);
      wr(5'd8, 32'hA5A5_0008);
      save_i = 1'b1;
      step();
      save_i = 1'b0;
      chk("R6 cwp after save", 32'(cwp_o), 32'd2);
      rd_a(5'd24);
      chk("R6 in sees caller out", rd_a_data, 32'hA5A5_0008);
      rd_b_idx = 5'd8; #1;
      chk("R6 own out fresh", rd_b_data, 32'd0);

      // R7 private locals
      set_cwp(3'd2);
      wr(5'd16, 32'hC0DE_0016);
      set_cwp(3'd1);
      rd_a(5'd16);
      chk("R7 other window local", rd_a_data, 32'd0);
      set_cwp(3'd2);
      rd_a(5'd16);
      chk("R7 own local", rd_a_data, 32'hC0DE_0016);

      // R8 read during write returns old value
      wr_en = 1'b1; wr_idx = 5'd6; wr_data = 32'h0BAD_F00D;
      rd_a(5'd6);
      chk("R8 same cycle old", rd_a_data, 32'd0);
      step();
      wr_en = 1'b0;
      #1;
      chk("R8 after edge new", rd_a_data, 32'h0BAD_F00D);

      // R9 mask bits above NWIN
      set_wim(32'hFFFF_FFFF);
      chk("R9 upper wim bits", wim_o, 32'h0000_00FF);
      set_wim(32'd0);

      // R11 CWP load beats save
      set_cwp(3'd4);
      cwp_wr_en = 1'b1; cwp_wr_val = 3'd6; save_i = 1'b1;
      step();
      cwp_wr_en = 1'b0; save_i = 1'b0;
      chk("R11 load priority", 32'(cwp_o), 32'd6);

      finish_run();
   end
endmodule